// File: doc/BRIEF.md
# Timer Compare Output Unit

This block keeps a programmable 16-bit match value and watches one of two free-running 16-bit timer counts, picked by a select input. When the picked count becomes equal to the match value, the block acts on a single output latch according to a 4-bit action code. The latch can be set, cleared or inverted, or it can be left as it is. In every active code a sticky interrupt flag is raised.

One code turns the unit into a period generator. On a match it sends a one-cycle reset pulse to whichever timer is selected, so that the timer wraps at the match value. It also sends a one-cycle start pulse to an analog converter. The latch drives the pin only while the external direction input selects output. Otherwise the pin is released, and the surrounding pad logic tri-states it when `pinOe` is low.

A match is taken on the cycle the selected count first equals the match value. A count that stays equal does not act again.

Top module: `cmpOutUnit`

## Requirements
- R1: After reset the match value is 0, the action code is 0000 (no action), the latch, `irqFlag`, `rstTimerA`, `rstTimerB` and `adcStart` are all 0.
- R2: With action code 1000, a new match sets the latch to 1 and raises `irqFlag`. Both are visible one clock edge after the cycle in which the equal count is presented.
- R3: With action code 1001, a new match clears the latch to 0 and raises `irqFlag` with the same timing as R2.
- R4: With action code 0010, each new match inverts the latch. A count that stays equal over later cycles neither inverts it again nor raises the flag again.
- R5: `useTimerB` = 0 compares against `timerA` and `useTimerB` = 1 compares against `timerB`. Equality on the unselected timer has no effect. Switching the selection onto a timer that already equals the match value counts as a new match.
- R6: With action code 1010, a new match raises `irqFlag` and leaves the latch unchanged.
- R7: With action code 1011, a new match raises `irqFlag` and leaves the latch unchanged. It also gives a one-cycle pulse on `adcStart` and on `rstTimerA` (when `useTimerB` = 0) or on `rstTimerB` (when `useTimerB` = 1), with the same timing as R2.
- R8: `irqFlag` stays 1 until a cycle with `flagClr` = 1. If a new match and `flagClr` fall in the same cycle, the flag stays 1.
- R9: Writing action code 0000 through `ctlWr` forces the latch to 0 at the next edge, even if a match occurs in the same cycle.
- R10: Every action code other than 0010, 1000, 1001, 1010 and 1011 is inert. A match changes neither the latch nor `irqFlag` and gives no pulses.
- R11: `pinOe` is the inverse of `dirIn` in the same cycle. `pinOut` shows the latch while `pinOe` = 1 and is 0 otherwise. The latch keeps its value while the pin is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmpWr | input | 1 | Write strobe for the match value |
| cmpWrData | input | 16 | New match value |
| ctlWr | input | 1 | Write strobe for the action code |
| ctlWrData | input | 4 | New action code |
| useTimerB | input | 1 | 0 selects `timerA`, 1 selects `timerB` |
| timerA | input | 16 | Count of the first timer |
| timerB | input | 16 | Count of the second timer |
| flagClr | input | 1 | Clear strobe for the interrupt flag |
| dirIn | input | 1 | Direction input, 1 releases the pin |
| pinOut | output | 1 | Pin level |
| pinOe | output | 1 | Pin drive enable |
| irqFlag | output | 1 | Sticky match flag |
| rstTimerA | output | 1 | One-cycle reset pulse to the first timer |
| rstTimerB | output | 1 | One-cycle reset pulse to the second timer |
| adcStart | output | 1 | One-cycle converter start pulse |

## Verification
The assertions assume that the reset is held low for at least one clock edge. They also assume that `flagClr`, `cmpWr` and `ctlWr` are single-cycle strobes that change only between edges. They further assume that a match followed by a held equal count is the normal case, which is why a trigger pulse can be expected to fall after one cycle. The stimulus changes all inputs on the falling edge and moves each timer off the match value before presenting it again, so every intended match is a fresh one. Writes of the match value and the action code are placed in cycles where no timer equals the match value, except where R9 asks for that overlap.

// File: rtl/cmpOutPkg.sv
package cmpOutPkg;

  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_OFF    = 4'b0000;
  localparam logic [MODE_W-1:0] MODE_TOGGLE = 4'b0010;
  localparam logic [MODE_W-1:0] MODE_SET    = 4'b1000;
  localparam logic [MODE_W-1:0] MODE_CLEAR  = 4'b1001;
  localparam logic [MODE_W-1:0] MODE_FLAG   = 4'b1010;
  localparam logic [MODE_W-1:0] MODE_TRIG   = 4'b1011;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic setPin;
    logic clrPin;
    logic togPin;
    logic forceLow;
    logic raiseFlag;
    logic fireTrig;
  } cmpStrobe_t;

endpackage

// File: rtl/cmpControl.sv
module cmpControl
  import cmpOutPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWr,
  input  logic [MODE_W-1:0] ctlWrData,
  input  logic              matchEdge,
  output cmpStrobe_t        strobes
);

  logic [MODE_W-1:0] modeQ;

  always_ff @(posedge clk) begin
    if (!rstN)      modeQ <= MODE_OFF;
    else if (ctlWr) modeQ <= ctlWrData;
  end

  always_comb begin
    strobes          = '0;
    strobes.forceLow = ctlWr && (ctlWrData == MODE_OFF);
    if (matchEdge) begin
      case (modeQ)
        MODE_SET: begin
          strobes.setPin    = 1'b1;
          strobes.raiseFlag = 1'b1;
        end
        MODE_CLEAR: begin
          strobes.clrPin    = 1'b1;
          strobes.raiseFlag = 1'b1;
        end
        MODE_TOGGLE: begin
          strobes.togPin    = 1'b1;
          strobes.raiseFlag = 1'b1;
        end
        MODE_FLAG: begin
          strobes.raiseFlag = 1'b1;
        end
        MODE_TRIG: begin
          strobes.raiseFlag = 1'b1;
          strobes.fireTrig  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  AST_ONE_PIN_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.setPin, strobes.clrPin, strobes.togPin})); // R2
  AST_ACT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    !matchEdge |-> !strobes.raiseFlag && !strobes.fireTrig); // R4

endmodule

// File: rtl/cmpDatapath.sv
module cmpDatapath
  import cmpOutPkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmpWr,
  input  logic [TIMER_W-1:0] cmpWrData,
  input  logic [TIMER_W-1:0] timerA,
  input  logic [TIMER_W-1:0] timerB,
  input  logic               useTimerB,
  input  logic               flagClr,
  input  cmpStrobe_t         strobes,
  output logic               matchEdge,
  output logic               pinLatch,
  output logic               irqFlag,
  output logic               rstTimerA,
  output logic               rstTimerB,
  output logic               adcStart
);

  localparam int NUM_TIMERS = 2;

  logic [TIMER_W-1:0]    cmpQ;
  logic [TIMER_W-1:0]    timerVal [NUM_TIMERS];
  logic [TIMER_W-1:0]    selVal;
  logic                  matchNow;
  logic                  matchPrevQ;
  logic [NUM_TIMERS-1:0] rstPulseQ;

  assign timerVal[0] = timerA;
  assign timerVal[1] = timerB;
  assign selVal      = timerVal[useTimerB];
  assign matchNow    = (selVal == cmpQ);
  assign matchEdge   = matchNow && !matchPrevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpQ       <= '0;
      matchPrevQ <= 1'b0;
    end else begin
      if (cmpWr) cmpQ <= cmpWrData;
      matchPrevQ <= matchNow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 pinLatch <= 1'b0;
    else if (strobes.forceLow) pinLatch <= 1'b0;
    else if (strobes.setPin)   pinLatch <= 1'b1;
    else if (strobes.clrPin)   pinLatch <= 1'b0;
    else if (strobes.togPin)   pinLatch <= !pinLatch;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  irqFlag <= 1'b0;
    else if (strobes.raiseFlag) irqFlag <= 1'b1;
    else if (flagClr)           irqFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) adcStart <= 1'b0;
    else       adcStart <= strobes.fireTrig;
  end

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_timerRst
    always_ff @(posedge clk) begin
      if (!rstN) rstPulseQ[t] <= 1'b0;
      else       rstPulseQ[t] <= strobes.fireTrig && (32'(useTimerB) == t);
    end
  end

  assign rstTimerA = rstPulseQ[0];
  assign rstTimerB = rstPulseQ[1];

  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    adcStart && !strobes.fireTrig |=> !adcStart); // R7
  AST_TRIG_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> irqFlag); // R7
  AST_ONE_TIMER_RST: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rstTimerB, rstTimerA})); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag && !flagClr |=> irqFlag); // R8
  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.forceLow |=> !pinLatch); // R9
  AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.setPin || strobes.clrPin || strobes.togPin || strobes.forceLow)
    |=> $stable(pinLatch)); // R6

endmodule

// File: rtl/cmpOutUnit.sv
module cmpOutUnit
  import cmpOutPkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmpWr,
  input  logic [TIMER_W-1:0] cmpWrData,
  input  logic               ctlWr,
  input  logic [MODE_W-1:0]  ctlWrData,
  input  logic               useTimerB,
  input  logic [TIMER_W-1:0] timerA,
  input  logic [TIMER_W-1:0] timerB,
  input  logic               flagClr,
  input  logic               dirIn,
  output logic               pinOut,
  output logic               pinOe,
  output logic               irqFlag,
  output logic               rstTimerA,
  output logic               rstTimerB,
  output logic               adcStart
);

  cmpStrobe_t strobes;
  logic       matchEdge;
  logic       pinLatch;

  cmpControl i_control (
    .clk       (clk),
    .rstN      (rstN),
    .ctlWr     (ctlWr),
    .ctlWrData (ctlWrData),
    .matchEdge (matchEdge),
    .strobes   (strobes)
  );

  cmpDatapath #(.TIMER_W(TIMER_W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .cmpWr     (cmpWr),
    .cmpWrData (cmpWrData),
    .timerA    (timerA),
    .timerB    (timerB),
    .useTimerB (useTimerB),
    .flagClr   (flagClr),
    .strobes   (strobes),
    .matchEdge (matchEdge),
    .pinLatch  (pinLatch),
    .irqFlag   (irqFlag),
    .rstTimerA (rstTimerA),
    .rstTimerB (rstTimerB),
    .adcStart  (adcStart)
  );

  assign pinOe  = !dirIn;
  assign pinOut = pinOe && pinLatch;

endmodule

// File: tb/test_cmpOutUnit.sv
module test_cmpOutUnit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmpWr = 1'b0;
  logic [15:0] cmpWrData = '0;
  logic        ctlWr = 1'b0;
  logic [3:0]  ctlWrData = '0;
  logic        useTimerB = 1'b0;
  logic [15:0] timerA = 16'h0005;
  logic [15:0] timerB = 16'h0007;
  logic        flagClr = 1'b0;
  logic        dirIn = 1'b0;
  logic        pinOut, pinOe, irqFlag, rstTimerA, rstTimerB, adcStart;

  typedef struct {
    logic [5:0] v;  // {pinOut, pinOe, irqFlag, rstTimerA, rstTimerB, adcStart}
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int       nRun = 0;
  int       nFail = 0;
  bit       done = 1'b0;

  always #2 clk = !clk;

  cmpOutUnit i_cmpOutUnit (
    .clk(clk), .rstN(rstN), .cmpWr(cmpWr), .cmpWrData(cmpWrData),
    .ctlWr(ctlWr), .ctlWrData(ctlWrData), .useTimerB(useTimerB),
    .timerA(timerA), .timerB(timerB), .flagClr(flagClr), .dirIn(dirIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqFlag(irqFlag),
    .rstTimerA(rstTimerA), .rstTimerB(rstTimerB), .adcStart(adcStart)
  );

  // monitor: compares each result one step after the posedge it belongs to
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        logic [5:0] got;
        e   = expQ.pop_front();
        got = {pinOut, pinOe, irqFlag, rstTimerA, rstTimerB, adcStart};
        nRun++;
        if (got !== e.v) begin
          nFail++;
          $display("FAIL %s: got pin/oe/flag/rstA/rstB/adc=%b expected %b",
                   e.tag, got, e.v);
        end
      end
    end
  end

  // driver: inputs set now apply to the next posedge; then step to the negedge
  task automatic tick(input logic [5:0] v, input string tag);
    expItem_t e;
    e.v   = v;
    e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    cmpWr   = 1'b0;
    ctlWr   = 1'b0;
    flagClr = 1'b0;
  endtask

  task automatic wrCtl(input logic [3:0] code);
    ctlWr     = 1'b1;
    ctlWrData = code;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick(6'b010000, "R1");                                   // reset state
    cmpWr = 1'b1; cmpWrData = 16'h0100; tick(6'b010000, "R1");
    wrCtl(4'b1000);                   tick(6'b010000, "R10");
    timerA = 16'h0100;                tick(6'b111000, "R2");  // set on match
    flagClr = 1'b1;                   tick(6'b110000, "R8");  // held equal, cleared
    timerA = 16'h0101;                tick(6'b110000, "R2");
    wrCtl(4'b1001);                   tick(6'b110000, "R3");
    timerA = 16'h0100;                tick(6'b011000, "R3");  // clear on match
    timerA = 16'h0101; flagClr = 1'b1; tick(6'b010000, "R8");
    wrCtl(4'b0010);                   tick(6'b010000, "R4");
    timerA = 16'h0100;                tick(6'b111000, "R4");  // toggle up
    flagClr = 1'b1;                   tick(6'b110000, "R4");  // held: no re-flag
    timerA = 16'h0102;                tick(6'b110000, "R4");
    timerA = 16'h0100; flagClr = 1'b1; tick(6'b011000, "R8"); // match beats clear
    timerA = 16'h0103; timerB = 16'h0100; flagClr = 1'b1;
                                      tick(6'b010000, "R5");  // unselected equal
    useTimerB = 1'b1;                 tick(6'b111000, "R5");  // switch onto equal
    timerB = 16'h0104; flagClr = 1'b1; tick(6'b110000, "R5");
    wrCtl(4'b1010);                   tick(6'b110000, "R6");
    timerB = 16'h0100;                tick(6'b111000, "R6");  // flag only
    timerB = 16'h0105; flagClr = 1'b1; tick(6'b110000, "R6");
    wrCtl(4'b1011);                   tick(6'b110000, "R7");
    timerB = 16'h0100;                tick(6'b111011, "R7");  // rstB + adc
                                      tick(6'b111000, "R7");  // single cycle
    timerB = 16'h0107;                tick(6'b111000, "R7");
    useTimerB = 1'b0; timerA = 16'h0100; tick(6'b111101, "R7"); // rstA + adc
    timerA = 16'h0106;                tick(6'b111000, "R7");
    dirIn = 1'b1;                     tick(6'b001000, "R11"); // released
    dirIn = 1'b0;                     tick(6'b111000, "R11"); // latch kept
    wrCtl(4'b0000);                   tick(6'b011000, "R9");
    wrCtl(4'b0010);                   tick(6'b011000, "R4");
    timerA = 16'h0100;                tick(6'b111000, "R4");  // toggle up again
    timerA = 16'h0106;                tick(6'b111000, "R4");
    timerA = 16'h0100; wrCtl(4'b0000); tick(6'b011000, "R9"); // write beats match
    timerA = 16'h0106; wrCtl(4'b0111); flagClr = 1'b1; tick(6'b010000, "R10");
    timerA = 16'h0100;                tick(6'b010000, "R10"); // inert code
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(4 * 5000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule